// File: doc/BRIEF.md
# Status Byte Serial Readout

This block builds an 8-bit device status byte and presents it one bit at a time on a serial data output while a status-read command is in force. The command decoder raises `start` for one cycle when the status-read opcode has been taken in. After that, each `adv` pulse moves the output to the next bit, one pulse for each serial clock edge on which data leaves the device. The byte goes out most significant bit first. After the last bit it starts again at the top for as long as chip select stays low.

The top bit reports whether the device is ready. It is not taken from the stored copy: it follows the live `ready` input for as long as it is the bit on the output. A host can therefore stop the serial clock on that bit and watch it rise when a self-timed operation ends. The other bits come from a snapshot that is taken again at the start of every byte. Each byte is therefore consistent within itself, and it is never older than one byte.

Top module: `stat_shift`

## Requirements
- R1: Out of reset `so_oe` is 0 and `so_d` is 0.
- R2: A `start` pulse while `cs_n` is low sets `so_oe` to 1 from the next cycle, and the first bit shown is bit 7.
- R3: Bit 6 is the value of `cmp_diff` when the byte was captured: 0 means the last compare matched, 1 means at least one bit differed.
- R4: Bits 5..3 carry the fixed code given by parameter `DENSITY` (default 3'b100), and bits 2..0 are always 0.
- R5: Each `adv` pulse while active moves the output down one bit position, in the order 7, 6, ..., 0.
- R6: An `adv` pulse on bit 0 returns the output to bit 7 and captures a new snapshot. A change of `cmp_diff` in the middle of a byte does not show in that byte; it shows in the next byte.
- R7: While bit 7 is on the output, `so_d` equals `ready` in the same cycle, so a 0 to 1 change of `ready` shows up with no `adv` pulse.
- R8: `cs_n` high forces `so_oe` to 0 from the next cycle. While the block is inactive, `adv` and `ready` leave `so_d` at 0, and `start` has no effect while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| start | input | 1 | One-cycle pulse: the status-read opcode has been accepted |
| adv | input | 1 | One-cycle pulse: move to the next output bit |
| ready | input | 1 | Live ready flag (1 = no self-timed operation running) |
| cmp_diff | input | 1 | Result of the last compare (1 = mismatch) |
| so_d | output | 1 | Serial data bit |
| so_oe | output | 1 | Output enable for the serial data pin |

## Verification
The hardest case to reach is the byte boundary with resampling, together with live polling. The bench has to change `cmp_diff` while the byte is half sent, then confirm that the old value stays in the rest of that byte and that the new value appears only after the wrap. For polling it stops the `adv` pulses with bit 7 on the output, holds `ready` low, and then raises it. `so_d` must follow in the same cycle with no pulse at all. The cs_n-high cases send `adv` and `start` pulses into an inactive block and check at the output that nothing came back to life.

// File: rtl/stat_shift.sv
module stat_shift #(
  parameter logic [2:0] DENSITY = 3'b100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic start,
  input  logic adv,
  input  logic ready,
  input  logic cmp_diff,
  output logic so_d,
  output logic so_oe
);

  logic       active;
  logic [2:0] idx;
  logic [6:0] snap;

  wire  [6:0] fresh = {cmp_diff, DENSITY, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= 3'd7;
      snap   <= '0;
    end else if (cs_n) begin
      active <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= 3'd7;
      snap   <= fresh;
    end else if (active && adv) begin
      if (idx == 3'd0) begin
        idx  <= 3'd7;
        snap <= fresh;
      end else begin
        idx  <= idx - 3'd1;
      end
    end
  end

  assign so_oe = active;
  assign so_d  = active & ((idx == 3'd7) ? ready : snap[idx]);

  a_r8_oe_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so_oe);

  a_r2_start_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cs_n) |=> (so_oe && idx == 3'd7));

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (active && adv && !cs_n && !start && idx != 3'd0) |=> (idx == $past(idx) - 3'd1));

  a_r6_wrap_resample: assert property (@(posedge clk) disable iff (!rst_n)
    (active && adv && !cs_n && !start && idx == 3'd0) |=> (idx == 3'd7 && snap[6] == $past(cmp_diff)));

  a_r4_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (snap[5:0] == {DENSITY, 3'b000}));

endmodule

// File: tb/stat_shift_tb.sv
module stat_shift_tb;
  logic clk = 1'b0;
  logic rst_n, cs_n, start, adv, ready, cmp_diff;
  logic so_d, so_oe;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  stat_shift u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start(start), .adv(adv),
    .ready(ready), .cmp_diff(cmp_diff), .so_d(so_d), .so_oe(so_oe)
  );

  // {ready, cmp_diff, expected byte}
  localparam logic [9:0] VEC [4] = '{
    {1'b1, 1'b0, 8'b1010_0000},
    {1'b0, 1'b1, 8'b0110_0000},
    {1'b1, 1'b1, 8'b1110_0000},
    {1'b0, 1'b0, 8'b0010_0000}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; cyc(); start = 1'b0;
  endtask

  task automatic pulse_adv();
    adv = 1'b1; cyc(); adv = 1'b0;
  endtask

  task automatic read_byte(input string tag, input logic [7:0] exp);
    for (int i = 7; i >= 0; i--) begin
      check(tag, so_d, exp[i]);
      pulse_adv();
    end
  endtask

  initial begin
    #150000;
    $display("FAIL watchdog: got timeout expected completion");
    fails++; checks++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; start = 1'b0; adv = 1'b0; ready = 1'b0; cmp_diff = 1'b0;
    cyc(); cyc();
    check("R1 oe", so_oe, 1'b0);
    check("R1 d", so_d, 1'b0);
    rst_n = 1'b1;
    cyc();

    // table: R2 R3 R4 R5
    foreach (VEC[k]) begin
      ready = VEC[k][9]; cmp_diff = VEC[k][8];
      cs_n = 1'b0;
      pulse_start();
      check("R2 oe", so_oe, 1'b1);
      read_byte("R3/R4/R5 byte", VEC[k][7:0]);
      // R6: repeats same byte when inputs unchanged
      read_byte("R6 repeat", VEC[k][7:0]);
      cs_n = 1'b1;
      cyc();
      check("R8 oe low", so_oe, 1'b0);
    end

    // R6: mid-byte change of compare result
    ready = 1'b1; cmp_diff = 1'b0; cs_n = 1'b0;
    pulse_start();
    check("R6 b7", so_d, 1'b1); pulse_adv();
    check("R6 b6", so_d, 1'b0); pulse_adv();
    cmp_diff = 1'b1;
    for (int i = 5; i >= 0; i--) begin
      check("R6 rest of old byte", so_d, (i == 5) ? 1'b1 : 1'b0);
      pulse_adv();
    end
    check("R6 new b7", so_d, 1'b1); pulse_adv();
    check("R6 new b6 resampled", so_d, 1'b1);

    // R7: live poll on bit 7
    for (int i = 0; i < 7; i++) pulse_adv();
    ready = 1'b0;
    cyc();
    check("R7 busy", so_d, 1'b0);
    cyc();
    check("R7 still busy", so_d, 1'b0);
    ready = 1'b1;
    #1;
    check("R7 live rise", so_d, 1'b1);
    cyc();
    check("R7 held", so_d, 1'b1);

    // R8: deselect, pulses ignored
    cs_n = 1'b1;
    cyc();
    check("R8 oe", so_oe, 1'b0);
    check("R8 d", so_d, 1'b0);
    pulse_adv();
    check("R8 adv ignored", so_oe, 1'b0);
    pulse_start();
    check("R8 start ignored oe", so_oe, 1'b0);
    check("R8 start ignored d", so_d, 1'b0);

    // R2: restart begins at bit 7 even after partial byte
    cs_n = 1'b0; cmp_diff = 1'b0; ready = 1'b1;
    pulse_start();
    pulse_adv(); pulse_adv();
    cs_n = 1'b1; cyc();
    cs_n = 1'b0; ready = 1'b0;
    pulse_start();
    read_byte("R2 restart at bit7", 8'b0010_0000);
    cs_n = 1'b1; cyc();

    // R1: reset while active
    cs_n = 1'b0; pulse_start();
    rst_n = 1'b0; cyc();
    check("R1 reset active oe", so_oe, 1'b0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule